// File: doc/BRIEF.md
# Control-Knob Delay Target Smoother

This block turns a stream of 10-bit converter readings from a delay-time knob into a steady delay target for a delay-line engine. It adds up a fixed window of valid readings (256 by default) into a wide sum. The sum is used directly as an address offset and is not divided. A sum below a floor value is raised to that floor, which is the shortest usable delay. The raised sum replaces the current target only when the two differ by a full deadband step. The target that is stored is always a multiple of four addresses.

A small state machine sequences the work. In `S_COLLECT` the block counts and sums readings. The transition `collect_done`, taken on the last reading of a window, moves it to `S_CLAMP`, where the floor is applied and the candidate is registered. The unconditional transition `clamp_done` moves it to `S_JUDGE`. There the deadband is tested, the target is conditionally replaced, and the sum and the reading count are emptied. The unconditional transition `judge_done` then returns the block to `S_COLLECT`. Conversion control for the converter is handled elsewhere. The block only consumes a valid strobe and the reading that comes with it.

Top module: `knob_delay_target`

## Requirements
- R1: After reset the target output is 0x00100 and the machine is in `S_COLLECT`. The target keeps that value until the first window has been judged.
- R2: A window is exactly 256 readings accepted with `adc_valid` high. Their plain sum is the candidate. The target does not change before the 256th reading. A new value appears on the output two clock cycles after the edge that captured that reading.
- R3: A clock cycle with `adc_valid` low has no effect on the sum or on the count, whatever value is present on `adc_value`.
- R4: A window sum below 0x00100 is replaced by exactly 0x00100 before the deadband test. That floor can itself be accepted as the new target.
- R5: If the candidate is greater than or equal to the target, it is accepted when candidate − target ≥ 256, that is, when the difference has a nonzero bit at position 8 or higher.
- R6: If the candidate is below the target, the difference is taken in one's complement (target − candidate − 1). The candidate is accepted only when target − candidate ≥ 257.
- R7: An accepted candidate is stored with bits 1:0 cleared, so the target is a multiple of 4.
- R8: After every judgement the sum and the reading count restart from zero, whether or not the target was replaced.
- R9: Strobes that arrive during the two cycles spent in `S_CLAMP` and `S_JUDGE` are dropped. They do not count toward the next window.
- R10: The target output changes only on the clock edge that leaves `S_JUDGE`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| adc_valid | input | 1 | High for one cycle per new reading |
| adc_value | input | 10 | Unsigned converter reading |
| delay_target | output | 18 | Desired delay offset in addresses |

## Verification
A reading sampled at edge P that completes a window produces its result on `delay_target` after edge P+2: one edge for the clamp register and one for the judgement. The bench therefore samples at falling edges. It confirms the old target at P and P+1 and the new one after P+2. It also confirms that the target is unchanged just before the 256th reading is driven. Windows are built to hit exact sums at the deadband edges on both sides (differences of 255, 256, 257 and the floor), and then pseudo-random windows with idle gaps follow. Strobes are injected during the two decision cycles. Every expected target comes from an arithmetic model of the clamp, one's-complement deadband and alignment rules.

// File: rtl/knob_target_pkg.sv
package knob_target_pkg;

    typedef enum logic [1:0] {
        S_COLLECT = 2'd0,
        S_CLAMP   = 2'd1,
        S_JUDGE   = 2'd2
    } knob_state_e;

endpackage

// File: rtl/knob_window_sum.sv
module knob_window_sum #(
    parameter int IN_W     = 10,
    parameter int SUM_W    = 18,
    parameter int NUM_READ = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             clear,
    input  logic [IN_W-1:0]  value,
    output logic [SUM_W-1:0] sum,
    output logic             last_take
);
    localparam int CNT_W = (NUM_READ > 1) ? $clog2(NUM_READ) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NUM_READ - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [SUM_W-1:0] sum_q;

    assign sum       = sum_q;
    assign last_take = take && (cnt_q == LAST_IDX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sum_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
            sum_q <= '0;
        end else if (take) begin
            cnt_q <= cnt_q + CNT_W'(1);
            sum_q <= sum_q + SUM_W'(value);
        end
    end

    // R2: each accepted reading adds exactly its value
    a_r2_sum_step: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !clear) |=> (sum_q == $past(sum_q) + SUM_W'($past(value))));

    // R3: idle cycles leave sum and count untouched
    a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!take && !clear) |=> ($stable(sum_q) && $stable(cnt_q)));

    // R8: clearing empties both registers
    a_r8_clear_empty: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (sum_q == '0 && cnt_q == '0));

endmodule

// File: rtl/knob_deadband.sv
module knob_deadband #(
    parameter int SUM_W      = 18,
    parameter int DEAD_SHIFT = 8,
    parameter int ALIGN_BITS = 2
) (
    input  logic [SUM_W-1:0] cand,
    input  logic [SUM_W-1:0] cur,
    output logic             accept,
    output logic [SUM_W-1:0] aligned
);
    logic [SUM_W:0]   diff;
    logic             neg;
    logic [SUM_W-1:0] mag;

    always_comb begin
        diff    = {1'b0, cand} - {1'b0, cur};
        neg     = diff[SUM_W];
        mag     = neg ? ~diff[SUM_W-1:0] : diff[SUM_W-1:0];
        accept  = |mag[SUM_W-1:DEAD_SHIFT];
        aligned = {cand[SUM_W-1:ALIGN_BITS], ALIGN_BITS'(0)};
    end

endmodule

// File: rtl/knob_delay_target.sv
module knob_delay_target
    import knob_target_pkg::*;
#(
    parameter int IN_W       = 10,
    parameter int SUM_W      = 18,
    parameter int NUM_READ   = 256,
    parameter int FLOOR_VAL  = 256,
    parameter int DEAD_SHIFT = 8,
    parameter int ALIGN_BITS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adc_valid,
    input  logic [IN_W-1:0]  adc_value,
    output logic [SUM_W-1:0] delay_target
);
    localparam logic [SUM_W-1:0] FLOOR = SUM_W'(FLOOR_VAL);

    knob_state_e      state_q, state_d;
    logic [SUM_W-1:0] target_q;
    logic [SUM_W-1:0] cand_q;
    logic [SUM_W-1:0] win_sum;
    logic             take, clear, last_take;
    logic             accept;
    logic [SUM_W-1:0] aligned;

    assign take         = adc_valid && (state_q == S_COLLECT);
    assign clear        = (state_q == S_JUDGE);
    assign delay_target = target_q;

    knob_window_sum #(
        .IN_W     (IN_W),
        .SUM_W    (SUM_W),
        .NUM_READ (NUM_READ)
    ) u_sum (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .clear     (clear),
        .value     (adc_value),
        .sum       (win_sum),
        .last_take (last_take)
    );

    knob_deadband #(
        .SUM_W      (SUM_W),
        .DEAD_SHIFT (DEAD_SHIFT),
        .ALIGN_BITS (ALIGN_BITS)
    ) u_dead (
        .cand    (cand_q),
        .cur     (target_q),
        .accept  (accept),
        .aligned (aligned)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_COLLECT;
        else        state_q <= state_d;
    end

    // transitions: collect_done, clamp_done, judge_done
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_COLLECT: if (last_take) state_d = S_CLAMP;
            S_CLAMP:   state_d = S_JUDGE;
            S_JUDGE:   state_d = S_COLLECT;
            default:   state_d = S_COLLECT;
        endcase
    end

    // outputs: floored candidate and target
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cand_q   <= FLOOR;
            target_q <= FLOOR;
        end else begin
            unique case (state_q)
                S_CLAMP: cand_q <= (win_sum < FLOOR) ? FLOOR : win_sum;
                S_JUDGE: if (accept) target_q <= aligned;
                default: ;
            endcase
        end
    end

    // R4: target never falls below the floor
    a_r4_floor: assert property (@(posedge clk) disable iff (!rst_n)
        delay_target >= FLOOR);

    // R7: target stays a multiple of 4 after each judgement
    a_r7_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_JUDGE && accept) |=> (delay_target[ALIGN_BITS-1:0] == '0));

    // R10: the target moves only when leaving S_JUDGE
    a_r10_hold_outside_judge: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_JUDGE) |=> $stable(delay_target));

    // R5/R6: a rejected candidate leaves the target alone
    a_r6_reject_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_JUDGE && !accept) |=> $stable(delay_target));

    // R9: the machine always comes back to collecting after judging
    a_r9_return_collect: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_JUDGE) |=> (state_q == S_COLLECT));

    // R2: the clamp state follows only from a completed window
    a_r2_window_end: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_COLLECT && !last_take) |=> (state_q == S_COLLECT));

endmodule

// File: tb/knob_delay_target_bench.sv
`timescale 1ns/1ps
module knob_delay_target_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        adc_valid = 1'b0;
    logic [9:0]  adc_value = '0;
    logic [17:0] delay_target;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    logic [17:0] model_tgt;
    logic [15:0] lfsr = 16'hACE1;

    always #4 clk = ~clk;

    knob_delay_target u_knob_delay_target (
        .clk          (clk),
        .rst_n        (rst_n),
        .adc_valid    (adc_valid),
        .adc_value    (adc_value),
        .delay_target (delay_target)
    );

    task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%05h expected=0x%05h", req, act, exp);
        end
    endtask

    function automatic logic [17:0] judge(input logic [17:0] tgt, input int s);
        int c, d;
        c = (s < 256) ? 256 : s;
        if (c >= int'(tgt)) d = c - int'(tgt);
        else                d = int'(tgt) - c - 1;
        if (d >= 256) return 18'(c) & 18'h3FFFC;
        return tgt;
    endfunction

    function automatic logic [15:0] step_lfsr(input logic [15:0] x);
        return {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
    endfunction

    // vals: 256 readings; gaps: insert idle cycles with junk values
    task automatic run_window(input int vals[256], input bit gaps, input string req);
        int s = 0;
        logic [17:0] old_t, exp_t;
        old_t = model_tgt;
        for (int i = 0; i < 256; i++) begin
            s += vals[i];
            if (gaps && (i % 7 == 3)) begin
                @(negedge clk);
                adc_valid = 1'b0;
                adc_value = 10'h3FF;
            end
            @(negedge clk);
            if (i == 255) chk("R2 target held before last reading", delay_target, old_t);
            adc_valid = 1'b1;
            adc_value = 10'(vals[i]);
        end
        exp_t = judge(old_t, s);
        @(posedge clk);
        @(negedge clk);
        chk("R10 target held in clamp cycle", delay_target, old_t);
        adc_valid = 1'b1; adc_value = 10'h3FF;   // dropped (R9)
        @(posedge clk);
        @(negedge clk);
        chk("R10 target held in judge cycle", delay_target, old_t);
        adc_valid = 1'b1; adc_value = 10'h3FF;   // dropped (R9)
        @(posedge clk);
        @(negedge clk);
        adc_valid = 1'b0; adc_value = 10'h155;
        chk(req, delay_target, exp_t);
        model_tgt = exp_t;
    endtask

    task automatic run_sum(input int s, input string req);
        int v[256];
        for (int i = 0; i < 256; i++) v[i] = (s / 256) + ((i < (s % 256)) ? 1 : 0);
        run_window(v, 1'b0, req);
    endtask

    initial begin
        model_tgt = 18'h00100;
        repeat (3) @(negedge clk);
        chk("R1 reset target", delay_target, 18'h00100);
        rst_n = 1'b1;
        // idle cycles with junk values must not count (R3)
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            adc_valid = 1'b0;
            adc_value = 10'(i * 51);
        end
        chk("R1 target held before any window", delay_target, 18'h00100);

        run_sum(0,            "R4 zero sum floored, equal -> held");
        run_sum(32'h1FF,      "R5 up by 255 rejected; R9 R3 R8 no leak");
        run_sum(32'h200,      "R5 up by 256 accepted");
        run_sum(32'h303,      "R7 accepted value aligned to 0x300");
        run_sum(32'h200,      "R6 down by 256 rejected (ones complement)");
        run_sum(32'h1FF,      "R6 down by 257 accepted, R7 -> 0x1FC");
        run_sum(32'h50,       "R4 small sum floored, down 252 rejected");
        run_sum(32'h3FF00,    "R5 full-scale sum accepted");
        run_sum(32'h3FE01,    "R6 down by 255 rejected");
        run_sum(3,            "R4 floor accepted from high target");
        run_sum(32'h8000,     "R8 fresh window after judgement");

        for (int w = 0; w < 16; w++) begin
            int v[256];
            logic [9:0] mask;
            mask = (w % 3 == 0) ? 10'h3FF : ((w % 3 == 1) ? 10'h0FF : 10'h00F);
            for (int i = 0; i < 256; i++) begin
                lfsr = step_lfsr(lfsr);
                v[i] = int'(lfsr[9:0] & mask);
            end
            run_window(v, 1'b1, "R3 R8 random window with idle gaps");
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule